// File: doc/BRIEF.md
# Spare Row Remapping Decoder

This block sits between a requester and a memory array that physically holds a few more rows than the capacity it advertises. A small one-time-programmable repair table records which physical rows are faulty and which spare row stands in for each. Once the table is written, every access whose logical row matches a valid repair entry is redirected to the spare. Every other access goes to the row of the same number. To the requester the memory looks flawless at its nominal size.

Each repair entry behaves like a fuse. Writing an entry sets it permanently, and any later write to the same entry is refused and flagged. When every entry is already in use and another repair is requested, the block raises a sticky flag saying the part cannot be repaired. A behavioural storage array is part of the block, so the redirection can be observed through ordinary reads and writes.

The physical row select is combinational from the logical address. Reads return their data one clock after the request.

Top module: `spare_row_remap`

## Requirements
- R1: An access row that matches no valid entry drives `phys_row` equal to `acc_row` (zero-extended), with `remapped` low, in the same cycle.
- R2: An access row that matches a valid entry drives `phys_row` = `LOG_ROWS` + that entry's spare index, with `remapped` high, in the same cycle.
- R3: While `remapped` is high, `phys_row` is never equal to `acc_row` and always lies in the spare region (at or above `LOG_ROWS`).
- R4: A program request (`prog_en` high at a clock edge) aimed at an empty entry stores `prog_row` and `prog_spare` in it. The entry is valid from the next cycle.
- R5: A program request aimed at an entry that is already valid leaves that entry unchanged. It sets `prog_error` from the next cycle, and `prog_error` stays high until reset.
- R6: If several valid entries hold the same faulty row, the entry with the lowest index supplies the spare.
- R7: A program request made while all `SPARES` entries are valid sets `unrepairable` from the next cycle, and it stays high until reset.
- R8: A write stores `acc_wdata` in the row selected by `phys_row`. A read returns that row's contents on `rd_data` one cycle later, so data written through a repaired logical row is read back from its spare.
- R9: After synchronous reset (`rst` high), no entry is valid, `prog_error` and `unrepairable` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the repair table (blank part) |
| prog_en | input | 1 | Program one repair entry this cycle |
| prog_entry | input | $clog2(SPARES) | Index of the entry to program |
| prog_row | input | $clog2(LOG_ROWS) | Faulty row to record |
| prog_spare | input | $clog2(SPARES) | Spare index that replaces the faulty row |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | $clog2(LOG_ROWS) | Logical row address |
| acc_wdata | input | WIDTH | Write data |
| phys_row | output | $clog2(LOG_ROWS+SPARES) | Physical row select |
| remapped | output | 1 | Current access hits a repair entry |
| rd_data | output | WIDTH | Read data, one cycle after the read |
| prog_error | output | 1 | Sticky: a fused entry was written again |
| unrepairable | output | 1 | Sticky: repair requested with no free entry |

## Verification
The bench uses the default build: 16 logical rows, 4 spares and 8-bit data. With these values the spare region is physical rows 16 to 19, and the complete table can be filled with only four program requests. That makes both the exhausted-table case and a duplicate faulty row held in two entries reachable in a short directed sequence. The narrow address also lets the bench check a data pattern written before a repair against one written after it through the same logical row.

// File: rtl/rowfix_pkg.sv
package rowfix_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic prog_error;
        logic unrepairable;
    } fuse_flags_t;

    function automatic acc_kind_e decode_access(input logic en, input logic we);
        if (!en)      return ACC_NONE;
        else if (we)  return ACC_WRITE;
        else          return ACC_READ;
    endfunction

endpackage

// File: rtl/fuse_table.sv
module fuse_table
    import rowfix_pkg::*;
#(
    parameter int LOG_ROWS = 16,
    parameter int SPARES   = 4,
    localparam int AW = $clog2(LOG_ROWS),
    localparam int SW = $clog2(SPARES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         prog_en,
    input  logic [SW-1:0]                prog_entry,
    input  logic [AW-1:0]                prog_row,
    input  logic [SW-1:0]                prog_spare,
    output logic [SPARES-1:0]            ent_valid,
    output logic [SPARES-1:0][AW-1:0]    ent_row,
    output logic [SPARES-1:0][SW-1:0]    ent_spare,
    output fuse_flags_t                  flags
);

    logic table_full;
    logic target_blown;

    assign table_full   = &ent_valid;
    assign target_blown = ent_valid[prog_entry];

    generate
        for (genvar g = 0; g < SPARES; g++) begin : g_fuse
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_valid[g] <= 1'b0;
                    ent_row[g]   <= '0;
                    ent_spare[g] <= '0;
                end else if (prog_en && prog_entry == SW'(g) && !ent_valid[g]) begin
                    ent_valid[g] <= 1'b1;
                    ent_row[g]   <= prog_row;
                    ent_spare[g] <= prog_spare;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (prog_en) begin
            if (target_blown) flags.prog_error   <= 1'b1;
            if (table_full)   flags.unrepairable <= 1'b1;
        end
    end

endmodule

// File: rtl/remap_match.sv
module remap_match #(
    parameter int LOG_ROWS = 16,
    parameter int SPARES   = 4,
    localparam int AW = $clog2(LOG_ROWS),
    localparam int SW = $clog2(SPARES),
    localparam int PW = $clog2(LOG_ROWS + SPARES)
) (
    input  logic [AW-1:0]                acc_row,
    input  logic [SPARES-1:0]            ent_valid,
    input  logic [SPARES-1:0][AW-1:0]    ent_row,
    input  logic [SPARES-1:0][SW-1:0]    ent_spare,
    output logic [PW-1:0]                phys_row,
    output logic                         remapped
);

    logic [SPARES-1:0] hit;
    logic [SW-1:0]     win_spare;

    generate
        for (genvar g = 0; g < SPARES; g++) begin : g_cmp
            assign hit[g] = ent_valid[g] && (ent_row[g] == acc_row);
        end
    endgenerate

    // Scan from the top index down so the lowest hitting entry is written last.
    always_comb begin
        win_spare = '0;
        for (int i = SPARES - 1; i >= 0; i--) begin
            if (hit[i]) win_spare = ent_spare[i];
        end
    end

    assign remapped = |hit;
    assign phys_row = remapped ? (PW'(LOG_ROWS) + PW'(win_spare)) : PW'(acc_row);

endmodule

// File: rtl/row_array.sv
module row_array
    import rowfix_pkg::*;
#(
    parameter int ROWS  = 20,
    parameter int WIDTH = 8,
    localparam int PW = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_kind_e        kind,
    input  logic [PW-1:0]    row,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (kind == ACC_WRITE) cells[row] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                    rdata <= '0;
        else if (kind == ACC_READ)  rdata <= cells[row];
    end

endmodule

// File: rtl/spare_row_remap.sv
module spare_row_remap
    import rowfix_pkg::*;
#(
    parameter int LOG_ROWS = 16,
    parameter int SPARES   = 4,
    parameter int WIDTH    = 8,
    localparam int AW        = $clog2(LOG_ROWS),
    localparam int SW        = $clog2(SPARES),
    localparam int PHYS_ROWS = LOG_ROWS + SPARES,
    localparam int PW        = $clog2(PHYS_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_en,
    input  logic [SW-1:0]    prog_entry,
    input  logic [AW-1:0]    prog_row,
    input  logic [SW-1:0]    prog_spare,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [AW-1:0]    acc_row,
    input  logic [WIDTH-1:0] acc_wdata,
    output logic [PW-1:0]    phys_row,
    output logic             remapped,
    output logic [WIDTH-1:0] rd_data,
    output logic             prog_error,
    output logic             unrepairable
);

    logic [SPARES-1:0]         ent_valid;
    logic [SPARES-1:0][AW-1:0] ent_row;
    logic [SPARES-1:0][SW-1:0] ent_spare;
    fuse_flags_t               flags;
    acc_kind_e                 kind;

    fuse_table #(.LOG_ROWS(LOG_ROWS), .SPARES(SPARES)) u_table (
        .clk        (clk),
        .rst        (rst),
        .prog_en    (prog_en),
        .prog_entry (prog_entry),
        .prog_row   (prog_row),
        .prog_spare (prog_spare),
        .ent_valid  (ent_valid),
        .ent_row    (ent_row),
        .ent_spare  (ent_spare),
        .flags      (flags)
    );

    remap_match #(.LOG_ROWS(LOG_ROWS), .SPARES(SPARES)) u_match (
        .acc_row   (acc_row),
        .ent_valid (ent_valid),
        .ent_row   (ent_row),
        .ent_spare (ent_spare),
        .phys_row  (phys_row),
        .remapped  (remapped)
    );

    assign kind = decode_access(acc_en, acc_we);

    row_array #(.ROWS(PHYS_ROWS), .WIDTH(WIDTH)) u_array (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .row   (phys_row),
        .wdata (acc_wdata),
        .rdata (rd_data)
    );

    assign prog_error   = flags.prog_error;
    assign unrepairable = flags.unrepairable;

endmodule

// File: rtl/spare_row_remap_chk.sv
module spare_row_remap_chk #(
    parameter int LOG_ROWS = 16,
    parameter int SPARES   = 4,
    localparam int AW = $clog2(LOG_ROWS),
    localparam int PW = $clog2(LOG_ROWS + SPARES)
) (
    input logic          clk,
    input logic          rst,
    input logic          prog_en,
    input logic [AW-1:0] acc_row,
    input logic [PW-1:0] phys_row,
    input logic          remapped,
    input logic          prog_error,
    input logic          unrepairable
);

    // R1
    a_r1_identity: assert property (@(posedge clk) disable iff (rst)
        !remapped |-> phys_row == PW'(acc_row));

    // R3
    a_r3_spare_region: assert property (@(posedge clk) disable iff (rst)
        remapped |-> (int'(phys_row) >= LOG_ROWS && phys_row != PW'(acc_row)));

    // R5
    a_r5_error_sticky: assert property (@(posedge clk) disable iff (rst)
        prog_error |=> prog_error);

    // R5
    a_r5_error_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_error) |-> $past(prog_en));

    // R7
    a_r7_unrep_sticky: assert property (@(posedge clk) disable iff (rst)
        unrepairable |=> unrepairable);

    // R7
    a_r7_unrep_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(unrepairable) |-> $past(prog_en));

endmodule

bind spare_row_remap spare_row_remap_chk #(.LOG_ROWS(LOG_ROWS), .SPARES(SPARES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .prog_en      (prog_en),
    .acc_row      (acc_row),
    .phys_row     (phys_row),
    .remapped     (remapped),
    .prog_error   (prog_error),
    .unrepairable (unrepairable)
);

// File: tb/tb_spare_row_remap.sv
module tb_spare_row_remap;

    localparam int LOG_ROWS = 16;
    localparam int SPARES   = 4;
    localparam int WIDTH    = 8;
    localparam int AW = $clog2(LOG_ROWS);
    localparam int SW = $clog2(SPARES);
    localparam int PW = $clog2(LOG_ROWS + SPARES);

    logic             clk = 1'b0;
    logic             rst;
    logic             prog_en;
    logic [SW-1:0]    prog_entry;
    logic [AW-1:0]    prog_row;
    logic [SW-1:0]    prog_spare;
    logic             acc_en;
    logic             acc_we;
    logic [AW-1:0]    acc_row;
    logic [WIDTH-1:0] acc_wdata;
    logic [PW-1:0]    phys_row;
    logic             remapped;
    logic [WIDTH-1:0] rd_data;
    logic             prog_error;
    logic             unrepairable;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    spare_row_remap #(.LOG_ROWS(LOG_ROWS), .SPARES(SPARES), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst),
        .prog_en(prog_en), .prog_entry(prog_entry), .prog_row(prog_row), .prog_spare(prog_spare),
        .acc_en(acc_en), .acc_we(acc_we), .acc_row(acc_row), .acc_wdata(acc_wdata),
        .phys_row(phys_row), .remapped(remapped), .rd_data(rd_data),
        .prog_error(prog_error), .unrepairable(unrepairable)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic program_entry(input int entry, input int row, input int spare);
        @(negedge clk);
        prog_en    = 1'b1;
        prog_entry = SW'(entry);
        prog_row   = AW'(row);
        prog_spare = SW'(spare);
        @(negedge clk);
        prog_en = 1'b0;
    endtask

    task automatic probe(input int row, input int exp_phys, input int exp_remap, input string req);
        @(negedge clk);
        acc_row = AW'(row);
        #1;
        check(req, int'(phys_row), exp_phys);
        check(req, int'(remapped), exp_remap);
    endtask

    task automatic write_row(input int row, input int data);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1;
        acc_row = AW'(row); acc_wdata = WIDTH'(data);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic read_check(input int row, input int exp_data, input string req);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_row = AW'(row);
        @(negedge clk);
        acc_en = 1'b0;
        check(req, int'(rd_data), exp_data);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 prog_error", int'(prog_error), 0);
        check("R9 unrepairable", int'(unrepairable), 0);
        check("R9 rd_data", int'(rd_data), 0);
        for (int r = 0; r < LOG_ROWS; r += 5) probe(r, r, 0, "R9 R1 blank table");
    endtask

    task automatic t_before_repair;
        write_row(3, 8'hA5);
        write_row(4, 8'h11);
        read_check(3, 8'hA5, "R8 read unrepaired row");
        probe(3, 3, 0, "R1 row 3 unrepaired");
    endtask

    task automatic t_program_hit;
        program_entry(0, 3, 2);
        probe(3, LOG_ROWS + 2, 1, "R2 R4 row 3 to spare 2");
        check("R3 faulty row not selected", int'(phys_row != PW'(3)), 1);
        probe(4, 4, 0, "R1 neighbour untouched");
        check("R4 no error on blank entry", int'(prog_error), 0);
        read_check(4, 8'h11, "R8 neighbour data intact");
        write_row(3, 8'h3C);
        read_check(3, 8'h3C, "R8 data lands in spare");
    endtask

    task automatic t_reprogram;
        program_entry(0, 7, 1);
        check("R5 prog_error set", int'(prog_error), 1);
        probe(3, LOG_ROWS + 2, 1, "R5 entry 0 unchanged");
        probe(7, 7, 0, "R5 new row not mapped");
        check("R5 prog_error sticky", int'(prog_error), 1);
        check("R7 not yet unrepairable", int'(unrepairable), 0);
    endtask

    task automatic t_duplicates;
        program_entry(1, 3, 0);
        probe(3, LOG_ROWS + 2, 1, "R6 entry 0 beats entry 1");
        program_entry(2, 9, 3);
        program_entry(3, 9, 1);
        probe(9, LOG_ROWS + 3, 1, "R6 entry 2 beats entry 3");
        check("R7 full table alone no flag", int'(unrepairable), 0);
    endtask

    task automatic t_exhausted;
        program_entry(1, 12, 1);
        check("R7 unrepairable set", int'(unrepairable), 1);
        probe(12, 12, 0, "R7 extra repair ignored");
        repeat (3) @(negedge clk);
        check("R7 unrepairable sticky", int'(unrepairable), 1);
    endtask

    initial begin
        rst = 1'b1; prog_en = 1'b0; prog_entry = '0; prog_row = '0; prog_spare = '0;
        acc_en = 1'b0; acc_we = 1'b0; acc_row = '0; acc_wdata = '0;
        t_reset();
        t_before_repair();
        t_program_hit();
        t_reprogram();
        t_duplicates();
        t_exhausted();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule